// File: doc/BRIEF.md
# Piecewise-linear hyperbolic tangent unit

This block produces an approximation of tanh for one signed 8-bit fixed-point sample with five fractional bits (a value range of -4.0 to just under +4.0, one LSB = 1/32). It is meant to sit after a neuron's accumulate-and-bias stage as the activation function. A sample is offered with a valid strobe, and the result appears on the output, registered, one clock later.

The curve is odd, so the unit only evaluates the non-negative half. It takes the magnitude of the input and records the sign. A bank of comparators finds which of eight straight-line segments contains the magnitude. The unit adds the segment's intercept to its slope times the distance from the segment start, rounded to five fractional bits. It then negates the result for negative inputs. The breakpoints are packed tighter near the knee of the curve, where it bends most. Above 2.5 the output saturates at one. No table holds a value for every input code. Each segment needs only two small constants.

Top module: `tanh_pwl`

## Requirements
- R1: For every input code, the signed output (read as output/32) is within 1.5 LSB (0.046875) of tanh(input/32). Both input and output use two's-complement Q3.5 coding.
- R2: For every input code x from 1 to 127, the output for -x is the exact two's-complement negation of the output for x.
- R3: Any input whose magnitude is at least 2.5 (code 80 or above, or -80 or below) gives exactly +1.0 (0x20), or -1.0 (0xE0) for negative inputs.
- R4: The most negative code, 0x80 (-4.0), gives 0xE0 (-1.0).
- R5: An input of zero gives an output of exactly zero.
- R6: Read as signed values, the outputs never decrease as the input code steps from -128 up to +127.
- R7: When in_valid is high at a rising clock edge, out_valid is high after that edge and out_data holds that sample's result. This also holds for samples presented on consecutive cycles.
- R8: After an edge where in_valid is low, out_valid is low and out_data keeps its previous value.
- R9: While rst_n is low, out_valid is 0 and out_data is 0x00.
- R10: At the segment start magnitudes 0, 8, 16, 24, 32, 40, 48 and 64 (codes), the output equals the fixed intercepts 0, 8, 15, 20, 24, 27, 29 and 31 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is present on in_data |
| in_data | input | 8 | Input sample, signed Q3.5 |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | 8 | Activation result, signed Q3.5 |

## Verification
Every result is due exactly one clock after the edge that accepted its sample. No other stage lies between the input and the output register. The bench drives a sample at a falling edge and reads out_valid and out_data at the next falling edge, one full capture edge later. A following idle cycle is used to confirm that the output holds. A back-to-back burst checks that each cycle's output belongs to the sample accepted on the edge just before. All 256 codes are swept, and the accuracy, symmetry and monotonicity checks are computed from that sweep.

// File: rtl/tanh_pkg.sv
package tanh_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAC_W     = 5;
  localparam int NUM_SEG    = 8;
  localparam int SEG_W      = $clog2(NUM_SEG);
  localparam int SLOPE_FRAC = 4;
  localparam int ONE        = 1 << FRAC_W;
  localparam int CLAMP_AT   = 80;
  localparam int PROD_W     = 2 * DATA_W;

  typedef struct packed {
    logic load;
  } strobe_t;

  // Segment start magnitudes (codes); denser near the knee.
  function automatic int segStart(input int k);
    case (k)
      0: return 0;
      1: return 8;
      2: return 16;
      3: return 24;
      4: return 32;
      5: return 40;
      6: return 48;
      default: return 64;
    endcase
  endfunction

  // Intercepts at each segment start, output LSBs.
  function automatic int segBase(input int k);
    case (k)
      0: return 0;
      1: return 8;
      2: return 15;
      3: return 20;
      4: return 24;
      5: return 27;
      6: return 29;
      default: return 31;
    endcase
  endfunction

  // Slopes in output LSBs per input code, with SLOPE_FRAC fraction bits.
  function automatic int segSlope(input int k);
    case (k)
      0: return 16;
      1: return 14;
      2: return 10;
      3: return 8;
      4: return 6;
      5: return 4;
      6: return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/tanh_ctrl.sv
module tanh_ctrl
  import tanh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strb,
  output logic    outValid
);
  always_comb strb.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/tanh_datapath.sv
module tanh_datapath
  import tanh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  logic                isNeg;
  logic [DATA_W-1:0]   mag;
  logic [NUM_SEG-1:0]  aboveStart;
  logic [SEG_W-1:0]    seg;
  logic [DATA_W-1:0]   offset;
  logic [PROD_W-1:0]   prod;
  logic [DATA_W-1:0]   interp;
  logic [DATA_W-1:0]   magOut;
  logic [DATA_W-1:0]   result;
  logic                clampHit;

  // Sign and magnitude; -4.0 maps to unsigned 128 without overflow.
  always_comb begin
    isNeg = inData[DATA_W-1];
    mag   = isNeg ? (~inData + DATA_W'(1)) : inData;
  end

  assign aboveStart[0] = 1'b1;
  for (genvar k = 1; k < NUM_SEG; k++) begin : g_cmp
    assign aboveStart[k] = (mag >= DATA_W'(segStart(k)));
  end

  always_comb begin
    seg = '0;
    for (int k = 1; k < NUM_SEG; k++)
      if (aboveStart[k]) seg = SEG_W'(k);
  end

  always_comb begin
    clampHit = (mag >= DATA_W'(CLAMP_AT));
    offset   = mag - DATA_W'(segStart(int'(seg)));
    prod     = PROD_W'(segSlope(int'(seg))) * PROD_W'(offset);
    interp   = DATA_W'((prod + PROD_W'(1 << (SLOPE_FRAC - 1))) >> SLOPE_FRAC);
    magOut   = clampHit ? DATA_W'(ONE) : (DATA_W'(segBase(int'(seg))) + interp);
    result   = isNeg ? (~magOut + DATA_W'(1)) : magOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outData <= '0;
    else if (strb.load) outData <= result;
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(outData) <= $signed(DATA_W'(ONE))) &&
    ($signed(outData) >= -$signed(DATA_W'(ONE))));
  // R5
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && inData == '0) |=> (outData == '0));
  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !inData[DATA_W-1]) |=> !outData[DATA_W-1]);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(outData));
  // R3
  clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !inData[DATA_W-1] && inData >= DATA_W'(CLAMP_AT))
      |=> (outData == DATA_W'(ONE)));
endmodule

// File: rtl/tanh_pwl.sv
module tanh_pwl
  import tanh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data
);
  strobe_t strb;

  tanh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rst_n),
    .inValid  (in_valid),
    .strb     (strb),
    .outValid (out_valid)
  );

  tanh_datapath u_dp (
    .clk     (clk),
    .rstN    (rst_n),
    .strb    (strb),
    .inData  (in_data),
    .outData (out_data)
  );
endmodule

// File: tb/tanh_pwl_test.sv
`timescale 1ns/1ps
module tanh_pwl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int outs [256];
  bit done = 0;

  tanh_pwl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sval(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
    check(out_data == 8'h00, "R9 data", sval(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every code with an idle cycle after each.
    for (int c = -128; c < 128; c++) begin
      logic [7:0] prev;
      real ideal, diff;
      in_valid = 1'b1;
      in_data  = 8'(c);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h5A;
      check(out_valid == 1'b1, "R7 valid", int'(out_valid), 1);
      outs[c + 128] = sval(out_data);
      ideal = $tanh(real'(c) / 32.0) * 32.0;
      diff  = real'(outs[c + 128]) - ideal;
      if (diff < 0.0) diff = -diff;
      check(diff <= 1.5, "R1 accuracy", outs[c + 128], int'(ideal));
      prev = out_data;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
      check(out_data == prev, "R8 hold", sval(out_data), sval(prev));
    end

    // R5
    check(outs[128] == 0, "R5 zero", outs[128], 0);
    // R4
    check(outs[0] == -32, "R4 most negative", outs[0], -32);
    // R3 clamp
    for (int m = 80; m < 128; m++) begin
      check(outs[128 + m] == 32, "R3 clamp pos", outs[128 + m], 32);
      check(outs[128 - m] == -32, "R3 clamp neg", outs[128 - m], -32);
    end
    // R2 symmetry
    for (int m = 1; m < 128; m++)
      check(outs[128 - m] == -outs[128 + m], "R2 symmetry", outs[128 - m], -outs[128 + m]);
    // R6 monotonic
    for (int i = 1; i < 256; i++)
      check(outs[i] >= outs[i - 1], "R6 monotonic", outs[i], outs[i - 1]);
    // R10 breakpoints
    begin
      int bpIn [8]  = '{0, 8, 16, 24, 32, 40, 48, 64};
      int bpOut [8] = '{0, 8, 15, 20, 24, 27, 29, 31};
      for (int k = 0; k < 8; k++)
        check(outs[128 + bpIn[k]] == bpOut[k], "R10 breakpoint", outs[128 + bpIn[k]], bpOut[k]);
    end

    // R7 back-to-back burst
    for (int i = 0; i <= 24; i++) begin
      if (i < 24) begin
        in_valid = 1'b1;
        in_data  = 8'(i * 11 - 128);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (i < 24) begin
        check(out_valid == 1'b1, "R7 burst valid", int'(out_valid), 1);
        check(sval(out_data) == outs[i * 11], "R7 burst data", sval(out_data), outs[i * 11]);
      end
    end

    // R9 reset again mid-run
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9 valid again", int'(out_valid), 0);
    check(out_data == 8'h00, "R9 data again", sval(out_data), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule